// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is the configuration port of a clock generator. It listens on a two-wire serial bus (SCL clock, SDA data, both open-drain). It accepts only one kind of transaction: a block write. That transaction carries an address byte, a command byte, a byte count and then a run of data bytes. The data bytes always fill the configuration registers from register 0 upward. There is no indexed addressing and no read path. The bus pins are sampled by the fast system clock through synchronizers. SDA is pulled low only through an output-enable, `sda_oe`.

Among the stored registers, a contiguous group drives per-output disable bits. A disabled clock output is forced to a solid low level. An enabled output passes its source clock through unchanged. The host may end a transfer with STOP after any whole byte. Every data byte that was fully acknowledged before the STOP is kept.

Top module: `cfg_blkwr_slave`

## Requirements
- R1: Only the address byte 0xD2 (7-bit address 0x69, write bit 0) is acknowledged. Any other address byte, including 0xD3 with the read bit set, gets no ACK. After such a byte every further byte is left unacknowledged until the next START.
- R2: The slave pulls SDA low (sda_oe = 1) for an ACK from the falling SCL edge after bit 8 until the falling SCL edge that ends the ninth clock. At all other times it releases SDA, so SDA reads high when the host is not driving it.
- R3: The command byte is always acknowledged when the address matched. Its value has no effect on what is stored.
- R4: A byte count from 1 to 32 is acknowledged. A count of 0 or above 32 is not acknowledged; the transaction is dropped and no data byte is stored. No register is written before the count byte has been acknowledged.
- R5: Data bytes land in order: the k-th data byte (k from 0) goes to register k. Register k is read at cfg_q[8k+7:8k]. Each byte is committed when its ACK clock ends.
- R6: A STOP after any complete data byte ends the transfer. All acknowledged bytes are kept, and registers beyond them keep their earlier values.
- R7: Data bytes after the 32nd in one transaction are not acknowledged.
- R8: Data byte positions 6 to 31 are acknowledged but discarded. cfg_q and clk_dis do not change.
- R9: A START, including a repeated START inside a transfer, restarts address matching. The next data byte goes to register 0 again.
- R10: Clock output i is disabled by bit (i mod 8) of register 1 + i/8. Register 1 bits 7..0 control outputs 7..0, and register 2 bits 3..0 control outputs 11..8. clk_dis[i] reflects that bit. clk_out[i] is held low while disabled and otherwise equals clk_src[i].
- R11: Register 2 bits 7..4 are reserved. They are stored and visible on cfg_q but drive no output.
- R12: After reset, all registers are 0, no output is disabled and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain ACK) |
| clk_src | input | NUM_OUT | Source clocks to be gated |
| clk_out | output | NUM_OUT | Gated clocks, low when disabled |
| clk_dis | output | NUM_OUT | Per-output disable bits |
| cfg_q | output | 8*NUM_DEF | Stored registers, register k at bits 8k+7:8k |

## Verification
The bench builds the block with its defaults: a 32-byte transfer limit, six stored registers, twelve gated outputs and two synchronizer stages. With a 32-byte limit, an overrun transfer of 33 data bytes fits in a short run. That one transfer exercises the NACK at the limit and the discarded byte positions 6 to 31. Twelve outputs make the disable group span two registers, one of them only half used, so the reserved upper nibble can be shown to drive nothing.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RX = 2'd1, PH_ACK = 2'd2} phase_t;
  typedef enum logic [1:0] {BK_ADDR = 2'd0, BK_CMD = 2'd1, BK_CNT = 2'd2, BK_DATA = 2'd3} kind_t;
endpackage

// File: rtl/cfgslv_sync.sv
// Pin synchronizers and bus event detection; all outputs registered.
module cfgslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_bit,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_pipe;
  logic [DEPTH-1:0] sda_pipe;
  logic scl_s, scl_d, sda_s, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign scl_d = scl_pipe[STAGES];
  assign sda_s = sda_pipe[STAGES-1];
  assign sda_d = sda_pipe[STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_hi   <= 1'b1;
      sda_bit  <= 1'b1;
      ev_start <= 1'b0;
      ev_stop  <= 1'b0;
      ev_rise  <= 1'b0;
      ev_fall  <= 1'b0;
    end else begin
      scl_hi   <= scl_s;
      sda_bit  <= sda_s;
      ev_start <= scl_s & scl_d & sda_d & ~sda_s;
      ev_stop  <= scl_s & scl_d & ~sda_d & sda_s;
      ev_rise  <= scl_s & ~scl_d;
      ev_fall  <= ~scl_s & scl_d;
    end
  end
endmodule

// File: rtl/cfgslv_fsm.sv
// Byte framing, ACK decision and data sequencing.
module cfgslv_fsm
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         MAX_DATA = 32,
  parameter int         NUM_DEF  = 6,
  parameter int         CW       = $clog2(MAX_DATA + 1),
  parameter int         RW       = (NUM_DEF > 1) ? $clog2(NUM_DEF) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          sda_bit,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [RW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output phase_t        phase,
  output kind_t         kind,
  output logic [CW-1:0] data_idx
);
  localparam logic [7:0]    MATCH_BYTE = {ADDR7, 1'b0};
  localparam logic [7:0]    MAX_CNT    = 8'(MAX_DATA);
  localparam logic [CW-1:0] MAX_IDX    = CW'(MAX_DATA);
  localparam logic [CW-1:0] DEF_IDX    = CW'(NUM_DEF);

  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       byte_ack;

  always_comb begin
    unique case (kind)
      BK_ADDR: byte_ack = (shreg == MATCH_BYTE);
      BK_CMD:  byte_ack = 1'b1;
      BK_CNT:  byte_ack = (shreg != 8'd0) && (shreg <= MAX_CNT);
      default: byte_ack = (data_idx < MAX_IDX);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      kind     <= BK_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      data_idx <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        phase    <= PH_RX;
        kind     <= BK_ADDR;
        bitcnt   <= '0;
        data_idx <= '0;
        sda_oe   <= 1'b0;
      end else if (ev_stop) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (ev_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_bit};
              bitcnt <= bitcnt + 4'd1;
            end else if (ev_fall && bitcnt == 4'd8) begin
              if (byte_ack) begin
                phase  <= PH_ACK;
                sda_oe <= 1'b1;
              end else begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
              end
            end
          end
          PH_ACK: begin
            if (ev_fall) begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
              bitcnt <= '0;
              unique case (kind)
                BK_ADDR: kind <= BK_CMD;
                BK_CMD:  kind <= BK_CNT;
                BK_CNT:  kind <= BK_DATA;
                default: begin
                  if (data_idx < DEF_IDX) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= data_idx[RW-1:0];
                    wr_data <= shreg;
                  end
                  data_idx <= data_idx + 1'b1;
                end
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgslv_regs.sv
// Defined configuration registers, one generated byte each.
module cfgslv_regs #(
  parameter int NUM_DEF = 6,
  parameter int RW      = (NUM_DEF > 1) ? $clog2(NUM_DEF) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_idx,
  input  logic [7:0]           wr_data,
  output logic [8*NUM_DEF-1:0] cfg_q
);
  for (genvar g = 0; g < NUM_DEF; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[8*g +: 8] <= 8'h00;
      else if (wr_en && wr_idx == RW'(g))
        cfg_q[8*g +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/cfgslv_outdis.sv
// Output-disable decode and active-low hold of disabled clocks.
module cfgslv_outdis #(
  parameter int NUM_OUT = 12,
  parameter int NREG    = (NUM_OUT + 7) / 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [8*NREG-1:0]   dis_regs,
  input  logic [NUM_OUT-1:0]  clk_src,
  output logic [NUM_OUT-1:0]  clk_dis,
  output logic [NUM_OUT-1:0]  clk_out
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) clk_dis[i] <= 1'b0;
      else     clk_dis[i] <= dis_regs[8*(i/8) + (i%8)];
    end
    assign clk_out[i] = clk_src[i] & ~clk_dis[i];
  end
endmodule

// File: rtl/cfg_blkwr_slave.sv
module cfg_blkwr_slave
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         MAX_DATA    = 32,
  parameter int         NUM_DEF     = 6,
  parameter int         NUM_OUT     = 12,
  parameter int         DIS_BASE    = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [NUM_OUT-1:0]   clk_src,
  output logic [NUM_OUT-1:0]   clk_out,
  output logic [NUM_OUT-1:0]   clk_dis,
  output logic [8*NUM_DEF-1:0] cfg_q
);
  localparam int CW   = $clog2(MAX_DATA + 1);
  localparam int RW   = (NUM_DEF > 1) ? $clog2(NUM_DEF) : 1;
  localparam int NREG = (NUM_OUT + 7) / 8;

  logic          scl_hi, sda_bit;
  logic          ev_start, ev_stop, ev_rise, ev_fall;
  logic          wr_en;
  logic [RW-1:0] wr_idx;
  logic [7:0]    wr_data;
  phase_t        phase;
  kind_t         kind;
  logic [CW-1:0] data_idx;

  cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_bit(sda_bit),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  cfgslv_fsm #(
    .ADDR7(ADDR7), .MAX_DATA(MAX_DATA), .NUM_DEF(NUM_DEF), .CW(CW), .RW(RW)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .sda_bit(sda_bit), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .phase(phase), .kind(kind), .data_idx(data_idx)
  );

  cfgslv_regs #(.NUM_DEF(NUM_DEF), .RW(RW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cfg_q(cfg_q)
  );

  cfgslv_outdis #(.NUM_OUT(NUM_OUT), .NREG(NREG)) u_outdis (
    .clk(clk), .rst(rst),
    .dis_regs(cfg_q[8*DIS_BASE +: 8*NREG]),
    .clk_src(clk_src), .clk_dis(clk_dis), .clk_out(clk_out)
  );
endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk
  import cfgslv_pkg::*;
#(
  parameter int MAX_DATA = 32,
  parameter int CW       = $clog2(MAX_DATA + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_hi,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          sda_oe,
  input logic          wr_en,
  input phase_t        phase,
  input kind_t         kind,
  input logic [CW-1:0] data_idx
);
  // R2: SDA is only pulled during an ACK slot
  p_oe_only_in_ack_r2: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> phase == PH_ACK);

  // R2: the pull changes only while SCL is low, except on bus events
  p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(ev_start) && !$past(ev_stop)) |-> !scl_hi);

  // R4: a register write happens only once the count has been accepted
  p_write_after_count_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> kind == BK_DATA);

  // R7: the data pointer never passes the transfer limit
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    data_idx <= CW'(MAX_DATA));

  // R9: a START restarts address matching with the pointer at 0
  p_start_restarts_r9: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> (phase == PH_RX && kind == BK_ADDR && data_idx == '0 && !sda_oe));
endmodule

bind cfg_blkwr_slave cfgslv_chk #(.MAX_DATA(MAX_DATA)) u_chk (
  .clk(clk), .rst(rst), .scl_hi(scl_hi), .ev_start(ev_start), .ev_stop(ev_stop),
  .sda_oe(sda_oe), .wr_en(wr_en), .phase(phase), .kind(kind), .data_idx(data_idx)
);

// File: tb/tb_cfg_blkwr_slave.sv
module tb_cfg_blkwr_slave;
  localparam int NUM_DEF  = 6;
  localparam int NUM_OUT  = 12;
  localparam int MAX_DATA = 32;
  localparam int Q        = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [NUM_OUT-1:0]   clk_src = '1;
  logic [NUM_OUT-1:0]   clk_out, clk_dis;
  logic [8*NUM_DEF-1:0] cfg_q;

  always #4 clk = ~clk;  // 125 MHz
  assign sda_line = ~(host_low | sda_oe);

  cfg_blkwr_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .clk_src(clk_src), .clk_out(clk_out), .clk_dis(clk_dis), .cfg_q(cfg_q)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NUM_DEF];
  logic [7:0] pay [40];
  logic       exp_ack_q [$];
  string      exp_tag_q [$];
  logic       obs_ack;
  event       ack_ev;
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  // Scoreboard monitor: compares each observed ACK bit with the queued expectation
  initial begin
    forever begin
      @(ack_ev);
      if (exp_ack_q.size() == 0) begin
        chk(1'b0, "scoreboard underflow", 64'(obs_ack), 64'd0);
      end else begin
        logic e;
        string t;
        e = exp_ack_q.pop_front();
        t = exp_tag_q.pop_front();
        chk(obs_ack == e, t, 64'(obs_ack), 64'(e));
      end
    end
  end

  task automatic bus_start();
    host_low = 1'b0; wq();
    scl = 1'b1; wq();
    host_low = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    host_low = 1'b1; wq();
    scl = 1'b1; wq();
    host_low = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp, input string tag);
    exp_ack_q.push_back(exp);
    exp_tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
    end
    host_low = 1'b0; wq();
    scl = 1'b1; wq();
    obs_ack = ~sda_line;
    -> ack_ev;
    wq();
    scl = 1'b0; wq();
    // R2: SDA released after the ninth clock ends
    chk(sda_line == 1'b1, "R2 SDA released after ACK clock", 64'(sda_line), 64'd1);
  endtask

  // Driver: one block write with expected ACKs and model update
  task automatic blk_write(input logic [7:0] ab, input logic [7:0] cmd, input logic [7:0] cnt,
                           input int ndata, input bit do_stop, input string tag);
    bit alive;
    logic e;
    bus_start();
    e = (ab == 8'hD2);
    send_byte(ab, e, {tag, " addr"});
    alive = e;
    send_byte(cmd, alive, {tag, " cmd"});
    e = alive && cnt != 8'd0 && cnt <= 8'(MAX_DATA);
    send_byte(cnt, e, {tag, " count"});
    alive = e;
    for (int k = 0; k < ndata; k++) begin
      e = alive && (k < MAX_DATA);
      send_byte(pay[k], e, $sformatf("%s data%0d", tag, k));
      if (e && k < NUM_DEF) model[k] = pay[k];
      alive = e;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < NUM_DEF; k++)
      chk(cfg_q[8*k +: 8] == model[k], $sformatf("%s reg%0d", tag, k),
          64'(cfg_q[8*k +: 8]), 64'(model[k]));
  endtask

  task automatic check_outputs(input string tag);
    logic [NUM_OUT-1:0] ed;
    for (int i = 0; i < NUM_OUT; i++) ed[i] = model[1 + i/8][i%8];
    chk(clk_dis == ed, {tag, " clk_dis"}, 64'(clk_dis), 64'(ed));
    chk(clk_out == (clk_src & ~ed), {tag, " clk_out"}, 64'(clk_out), 64'(clk_src & ~ed));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < NUM_DEF; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R12: reset state
    check_regs("R12 reset");
    chk(clk_dis == '0, "R12 no output disabled", 64'(clk_dis), 64'd0);
    chk(sda_oe == 1'b0, "R12 SDA released", 64'(sda_oe), 64'd0);

    // R5 / R10: full write of six bytes
    pay[0] = 8'h11; pay[1] = 8'h3C; pay[2] = 8'h09;
    pay[3] = 8'h44; pay[4] = 8'h55; pay[5] = 8'h66;
    blk_write(8'hD2, 8'h00, 8'd6, 6, 1'b1, "R5 full");
    check_regs("R5 sequential fill");
    check_outputs("R10 decode");
    clk_src = 12'hA5A; wq();
    check_outputs("R10 pattern");
    clk_src = '1;

    // R3: non-zero command byte is ignored
    pay[0] = 8'hA1; pay[1] = 8'h00;
    blk_write(8'hD2, 8'h7E, 8'd2, 2, 1'b1, "R3 cmd");
    check_regs("R3 command ignored");
    check_outputs("R10 after rewrite");

    // R1: wrong address and read bit
    pay[0] = 8'hEE; pay[1] = 8'hEE;
    blk_write(8'hD4, 8'h00, 8'd2, 2, 1'b1, "R1 wrong addr");
    check_regs("R1 wrong addr no write");
    blk_write(8'hD3, 8'h00, 8'd2, 2, 1'b1, "R1 read bit");
    check_regs("R1 read bit no write");

    // R4: illegal counts
    blk_write(8'hD2, 8'h00, 8'd0, 2, 1'b1, "R4 count0");
    check_regs("R4 count0 no write");
    blk_write(8'hD2, 8'h00, 8'd33, 2, 1'b1, "R4 count33");
    check_regs("R4 count33 no write");

    // R6: stop after two of five announced bytes
    pay[0] = 8'h5A; pay[1] = 8'hC3;
    blk_write(8'hD2, 8'h00, 8'd5, 2, 1'b1, "R6 partial");
    check_regs("R6 partial kept");

    // R9: repeated START restarts at register 0
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03;
    blk_write(8'hD2, 8'h00, 8'd4, 3, 1'b0, "R9 first");
    pay[0] = 8'h70; pay[1] = 8'h80;
    blk_write(8'hD2, 8'h00, 8'd2, 2, 1'b1, "R9 restart");
    check_regs("R9 pointer reset");

    // R7 / R8: 33 data bytes
    for (int k = 0; k < 33; k++) pay[k] = 8'(8'h20 + k);
    pay[1] = 8'h00; pay[2] = 8'h00;
    blk_write(8'hD2, 8'h00, 8'd32, 33, 1'b1, "R7 R8 overrun");
    check_regs("R8 positions 6+ discarded");
    check_outputs("R8 outputs unchanged");

    // R11: reserved bits stored but inert
    pay[0] = 8'h00; pay[1] = 8'h00; pay[2] = 8'hF5;
    blk_write(8'hD2, 8'h00, 8'd3, 3, 1'b1, "R11 reserved");
    check_regs("R11 reserved stored");
    chk(clk_dis == 12'h500, "R11 reserved inert", 64'(clk_dis), 64'h500);
    check_outputs("R11 outputs");

    wq();
    chk(exp_ack_q.size() == 0, "scoreboard drained", 64'(exp_ack_q.size()), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule